// File: doc/BRIEF.md
# Execution Mode, Privilege and Stack Selector

This block follows whether the core is running ordinary code (Thread mode) or servicing an exception (Handler mode), and from that and a two-bit control register it derives the effective privilege level and which of two banked stack pointers is live. One pointer serves the main stack. The other serves the process stack. Exception entry and exit strobes move the mode. A control-register write port carries a qualifier that says whether the writer runs privileged. A stack-pointer write port updates whichever pointer is selected at that moment.

Out of reset the block runs a short boot sequence on a simple memory read interface. It first fetches the initial main stack pointer from byte address 0x00000000, then the reset program counter from byte address 0x00000004. Until both words have arrived, it ignores every other input. The reset link-register value is also exported for the surrounding core.

Top module: `exec_mode_ctl`

## Requirements
- R1: While reset is asserted, mode_o is 0 (Thread), priv_o is 1, psp_active_o is 0, ctrl_rdata_o is 0x00000000, ready_o is 0 and lr_init_o is 0xFFFFFFFF.
- R2: After reset, the block reads address 0x00000000 first and then 0x00000004. Each word is taken in the cycle where boot_req_o and boot_valid_i are both high. The first word, with bits[1:0] cleared, becomes the main stack pointer. The second word, with bit[0] cleared, appears on pc_init_o. ready_o rises in the cycle after the second word is taken.
- R3: A cycle with exc_entry_i high sets mode_o to 1 (Handler) from the next cycle on. A cycle with exc_return_i and ret_to_thread_i high and exc_entry_i low sets mode_o to 0. A return with ret_to_thread_i low leaves the block in Handler mode.
- R4: In Thread mode, control bit[1]=0 selects the main stack pointer and bit[1]=1 selects the process stack pointer, shown on psp_active_o and sp_rdata_o.
- R5: In Thread mode, priv_o is the inverse of control bit[0] (0 means privileged). In Handler mode, priv_o is always 1.
- R6: In Handler mode, the main stack pointer is always used. Control bit[1] reads as 0, and writes to it are ignored. Writes to bit[0] are still taken.
- R7: A control write with ctrl_wr_priv_i low leaves the control register unchanged.
- R8: Control bits[31:2] read as zero, whatever value is written.
- R9: A stack-pointer write stores the data with bits[1:0] cleared into the currently selected pointer only. The other pointer keeps its value.
- R10: Before ready_o is high, control, stack-pointer and exception inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boot_req_o | output | 1 | Boot word read request |
| boot_addr_o | output | 32 | Byte address of boot word |
| boot_valid_i | input | 1 | Boot read data valid |
| boot_rdata_i | input | 32 | Boot read data |
| ready_o | output | 1 | Boot sequence finished |
| exc_entry_i | input | 1 | Exception entry strobe |
| exc_return_i | input | 1 | Exception return strobe |
| ret_to_thread_i | input | 1 | Return goes back to Thread level |
| ctrl_wr_i | input | 1 | Control register write |
| ctrl_wr_priv_i | input | 1 | Writer is privileged |
| ctrl_wdata_i | input | 32 | Control write data |
| sp_wr_i | input | 1 | Selected stack pointer write |
| sp_wdata_i | input | 32 | Stack pointer write data |
| mode_o | output | 1 | 0 Thread, 1 Handler |
| priv_o | output | 1 | 1 when execution is privileged |
| psp_active_o | output | 1 | 1 when process stack pointer is live |
| sp_rdata_o | output | 32 | Value of the live stack pointer |
| ctrl_rdata_o | output | 32 | Control register readback |
| pc_init_o | output | 32 | Reset program counter |
| lr_init_o | output | 32 | Reset link register value |

## Verification
The selection logic is driven through Thread mode with each control value, then into a nested Handler state and back. This separates a design that gates stack choice and privilege by mode from one that reads the control bits directly. The stack-pointer writes use unaligned data and alternate between the two banks, so a lost alignment mask or a write that lands in the wrong bank shows up as a wrong readback after the mode or control change. Control writes are issued unprivileged, in Handler mode, with reserved bits set, and during boot. Each of these is checked against a readback that would differ if the write had been taken.

// File: rtl/exec_mode_pkg.sv
package exec_mode_pkg;
  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    BOOT_SP   = 2'd0,
    BOOT_PC   = 2'd1,
    BOOT_DONE = 2'd2
  } boot_st_e;
endpackage

// File: rtl/emc_boot_seq.sv
module emc_boot_seq #(
  parameter int unsigned DW = 32,
  parameter logic [DW-1:0] SP_VEC = '0,
  parameter logic [DW-1:0] PC_VEC = DW'(4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          req_o,
  output logic [DW-1:0] addr_o,
  input  logic          valid_i,
  input  logic [DW-1:0] rdata_i,
  output logic          sp_load_o,
  output logic [DW-1:0] sp_val_o,
  output logic [DW-1:0] pc_o,
  output logic          done_o
);
  import exec_mode_pkg::*;

  boot_st_e st_q;
  logic [DW-1:0] pc_q;

  assign req_o     = (st_q != BOOT_DONE);
  assign addr_o    = (st_q == BOOT_PC) ? PC_VEC : SP_VEC;
  assign sp_load_o = (st_q == BOOT_SP) && valid_i;
  assign sp_val_o  = rdata_i;
  assign pc_o      = pc_q;
  assign done_o    = (st_q == BOOT_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= BOOT_SP;
      pc_q <= '0;
    end else begin
      case (st_q)
        BOOT_SP: if (valid_i) st_q <= BOOT_PC;
        BOOT_PC: if (valid_i) begin
          st_q <= BOOT_DONE;
          pc_q <= {rdata_i[DW-1:1], 1'b0};
        end
        default: st_q <= BOOT_DONE;
      endcase
    end
  end

  p_done_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  p_pc_after_sp_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == BOOT_PC) |=> (st_q != BOOT_SP));
endmodule

// File: rtl/emc_mode_fsm.sv
module emc_mode_fsm (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 entry_i,
  input  logic                 ret_i,
  input  logic                 to_thread_i,
  output exec_mode_pkg::mode_e mode_o
);
  import exec_mode_pkg::*;

  mode_e mode_q;
  assign mode_o = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_THREAD;
    else if (en_i) begin
      if (entry_i)                 mode_q <= MODE_HANDLER;
      else if (ret_i && to_thread_i) mode_q <= MODE_THREAD;
    end
  end

  p_entry_handler_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && entry_i |=> mode_q == MODE_HANDLER);
  p_ret_thread_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && ret_i && to_thread_i && !entry_i |=> mode_q == MODE_THREAD);
  p_nested_ret_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q == MODE_HANDLER && !to_thread_i |=> mode_q == MODE_HANDLER);
endmodule

// File: rtl/emc_ctrl_reg.sv
module emc_ctrl_reg #(
  parameter int unsigned DW = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  exec_mode_pkg::mode_e mode_i,
  input  logic                 wr_i,
  input  logic                 wr_priv_i,
  input  logic [DW-1:0]        wdata_i,
  output logic                 sel_psp_o,
  output logic                 unpriv_o,
  output logic [DW-1:0]        rdata_o
);
  import exec_mode_pkg::*;

  logic [1:0] ctrl_q;
  logic       in_handler;
  logic       unused_hi;

  assign unused_hi  = ^wdata_i[DW-1:2];
  assign in_handler = (mode_i == MODE_HANDLER);
  assign sel_psp_o  = ctrl_q[1];
  assign unpriv_o   = ctrl_q[0];
  assign rdata_o    = {{(DW-2){1'b0}}, ctrl_q[1] & ~in_handler, ctrl_q[0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= 2'b00;
    else if (en_i && wr_i && wr_priv_i) begin
      ctrl_q[0] <= wdata_i[0];
      if (!in_handler) ctrl_q[1] <= wdata_i[1];
    end
  end

  p_unpriv_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wr_priv_i |=> $stable(ctrl_q));
  p_handler_bit1_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_handler |=> $stable(ctrl_q[1]));
  p_gated_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ctrl_q));
endmodule

// File: rtl/emc_sp_bank.sv
module emc_sp_bank #(
  parameter int unsigned DW    = 32,
  parameter int unsigned ALIGN = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          use_psp_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [DW-1:0] ALIGN_MASK = {{(DW-ALIGN){1'b1}}, {ALIGN{1'b0}}};

  logic [DW-1:0] msp_q, psp_q;

  assign rdata_o = use_psp_i ? psp_q : msp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msp_q <= '0;
      psp_q <= '0;
    end else if (load_i) begin
      msp_q <= load_val_i & ALIGN_MASK;
    end else if (wr_i) begin
      if (use_psp_i) psp_q <= wdata_i & ALIGN_MASK;
      else           msp_q <= wdata_i & ALIGN_MASK;
    end
  end

  p_psp_untouched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !use_psp_i |=> $stable(psp_q));
  p_msp_untouched_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && use_psp_i && !load_i |=> $stable(msp_q));
endmodule

// File: rtl/exec_mode_ctl.sv
module exec_mode_ctl #(
  parameter int unsigned   DW       = 32,
  parameter int unsigned   SP_ALIGN = 2,
  parameter logic [DW-1:0] SP_VEC   = '0,
  parameter logic [DW-1:0] PC_VEC   = DW'(4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          boot_req_o,
  output logic [DW-1:0] boot_addr_o,
  input  logic          boot_valid_i,
  input  logic [DW-1:0] boot_rdata_i,
  output logic          ready_o,
  input  logic          exc_entry_i,
  input  logic          exc_return_i,
  input  logic          ret_to_thread_i,
  input  logic          ctrl_wr_i,
  input  logic          ctrl_wr_priv_i,
  input  logic [DW-1:0] ctrl_wdata_i,
  input  logic          sp_wr_i,
  input  logic [DW-1:0] sp_wdata_i,
  output logic          mode_o,
  output logic          priv_o,
  output logic          psp_active_o,
  output logic [DW-1:0] sp_rdata_o,
  output logic [DW-1:0] ctrl_rdata_o,
  output logic [DW-1:0] pc_init_o,
  output logic [DW-1:0] lr_init_o
);
  import exec_mode_pkg::*;

  logic          sp_load, done, sel_psp, unpriv, use_psp;
  logic [DW-1:0] sp_boot_val;
  mode_e         mode;

  emc_boot_seq #(.DW(DW), .SP_VEC(SP_VEC), .PC_VEC(PC_VEC)) u_boot (
    .clk_i, .rst_ni,
    .req_o(boot_req_o), .addr_o(boot_addr_o),
    .valid_i(boot_valid_i), .rdata_i(boot_rdata_i),
    .sp_load_o(sp_load), .sp_val_o(sp_boot_val),
    .pc_o(pc_init_o), .done_o(done)
  );

  emc_mode_fsm u_mode (
    .clk_i, .rst_ni, .en_i(done),
    .entry_i(exc_entry_i), .ret_i(exc_return_i),
    .to_thread_i(ret_to_thread_i), .mode_o(mode)
  );

  emc_ctrl_reg #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .en_i(done), .mode_i(mode),
    .wr_i(ctrl_wr_i), .wr_priv_i(ctrl_wr_priv_i), .wdata_i(ctrl_wdata_i),
    .sel_psp_o(sel_psp), .unpriv_o(unpriv), .rdata_o(ctrl_rdata_o)
  );

  // handler always runs on the main stack
  assign use_psp = (mode == MODE_THREAD) && sel_psp;

  emc_sp_bank #(.DW(DW), .ALIGN(SP_ALIGN)) u_sp (
    .clk_i, .rst_ni,
    .load_i(sp_load), .load_val_i(sp_boot_val),
    .wr_i(sp_wr_i && done), .wdata_i(sp_wdata_i),
    .use_psp_i(use_psp), .rdata_o(sp_rdata_o)
  );

  assign ready_o      = done;
  assign mode_o       = mode;
  assign psp_active_o = use_psp;
  assign priv_o       = (mode == MODE_HANDLER) || !unpriv;
  assign lr_init_o    = '1;

  p_handler_msp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> !psp_active_o && ctrl_rdata_o[1] == 1'b0);
  p_handler_priv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o |-> priv_o);
  p_pc_even_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> pc_init_o[0] == 1'b0);
  p_quiet_boot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(mode_o) && $stable(ctrl_rdata_o));
endmodule

// File: tb/exec_mode_ctl_bench.sv
`timescale 1ns/1ps
module exec_mode_ctl_bench;
  localparam logic [31:0] SP_WORD = 32'h2000_1003;
  localparam logic [31:0] PC_WORD = 32'h0000_0123;

  typedef struct {
    string       req;
    int          sel;
    logic [31:0] exp;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_req, boot_valid = 1'b0, ready;
  logic [31:0] boot_addr, boot_rdata = '0;
  logic exc_entry = 0, exc_return = 0, ret_thread = 0;
  logic ctrl_wr = 0, ctrl_priv = 0, sp_wr = 0;
  logic [31:0] ctrl_wdata = '0, sp_wdata = '0;
  logic mode, priv, psp_active;
  logic [31:0] sp_rdata, ctrl_rdata, pc_init, lr_init;

  int checks = 0, failures = 0;
  bit finished = 0;
  exp_t exp_q[$];
  exp_t item;
  logic [31:0] addr_log[$];

  always #2 clk = ~clk;

  exec_mode_ctl u_exec_mode_ctl (
    .clk_i(clk), .rst_ni(rst_n),
    .boot_req_o(boot_req), .boot_addr_o(boot_addr),
    .boot_valid_i(boot_valid), .boot_rdata_i(boot_rdata),
    .ready_o(ready),
    .exc_entry_i(exc_entry), .exc_return_i(exc_return), .ret_to_thread_i(ret_thread),
    .ctrl_wr_i(ctrl_wr), .ctrl_wr_priv_i(ctrl_priv), .ctrl_wdata_i(ctrl_wdata),
    .sp_wr_i(sp_wr), .sp_wdata_i(sp_wdata),
    .mode_o(mode), .priv_o(priv), .psp_active_o(psp_active),
    .sp_rdata_o(sp_rdata), .ctrl_rdata_o(ctrl_rdata),
    .pc_init_o(pc_init), .lr_init_o(lr_init)
  );

  // boot memory: answers whatever address is requested
  always @(negedge clk) begin
    boot_valid <= boot_req;
    boot_rdata <= (boot_addr == 32'h0) ? SP_WORD : PC_WORD;
  end

  always @(posedge clk)
    if (rst_n && boot_req && boot_valid) addr_log.push_back(boot_addr);

  function automatic logic [31:0] pick(int sel);
    case (sel)
      0: return {31'b0, mode};
      1: return {31'b0, priv};
      2: return {31'b0, psp_active};
      3: return sp_rdata;
      4: return ctrl_rdata;
      5: return pc_init;
      6: return lr_init;
      default: return {31'b0, ready};
    endcase
  endfunction

  task automatic compare(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk)
    while (exp_q.size() > 0) begin
      item = exp_q.pop_front();
      compare(item.req, pick(item.sel), item.exp);
    end

  task automatic expect_out(string req, int sel, logic [31:0] val);
    exp_t e;
    e.req = req; e.sel = sel; e.exp = val;
    exp_q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk); #1;
    exc_entry = 0; exc_return = 0; ret_thread = 0;
    ctrl_wr = 0; sp_wr = 0;
  endtask

  task automatic do_ctrl(logic [31:0] d, logic p);
    @(negedge clk); ctrl_wr = 1; ctrl_priv = p; ctrl_wdata = d; tick();
  endtask

  task automatic do_sp(logic [31:0] d);
    @(negedge clk); sp_wr = 1; sp_wdata = d; tick();
  endtask

  task automatic do_exc(logic en, logic rt, logic th);
    @(negedge clk); exc_entry = en; exc_return = rt; ret_thread = th; tick();
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    expect_out("R1 mode", 0, 0);
    expect_out("R1 priv", 1, 1);
    expect_out("R1 psp_active", 2, 0);
    expect_out("R1 ctrl", 4, 0);
    expect_out("R1 lr", 6, 32'hFFFF_FFFF);
    expect_out("R1 ready", 7, 0);
    repeat (3) @(negedge clk);
    // R10: inputs during boot are dropped
    rst_n = 1;
    ctrl_wr = 1; ctrl_priv = 1; ctrl_wdata = 32'h3;
    exc_entry = 1; sp_wr = 1; sp_wdata = 32'h1234_5678;
    tick();
    tick();
    tick();
    expect_out("R2 ready", 7, 1);
    expect_out("R2 msp", 3, 32'h2000_1000);
    expect_out("R2 pc", 5, 32'h0000_0122);
    expect_out("R10 ctrl", 4, 0);
    expect_out("R10 mode", 0, 0);
    @(negedge clk);
    compare("R2 read count", addr_log.size(), 2);
    if (addr_log.size() >= 2) begin
      compare("R2 first addr", addr_log[0], 32'h0);
      compare("R2 second addr", addr_log[1], 32'h4);
    end

    // R9 main stack write, unaligned data
    do_sp(32'h2000_0FF7);
    expect_out("R9 msp", 3, 32'h2000_0FF4);
    // R4 switch to process stack
    do_ctrl(32'h2, 1);
    expect_out("R4 psp_active", 2, 1);
    expect_out("R4 ctrl", 4, 32'h2);
    do_sp(32'h1000_0ABE);
    expect_out("R9 psp", 3, 32'h1000_0ABC);
    // R5/R8 unprivileged thread, reserved bits set
    do_ctrl(32'hFFFF_FFFB, 1);
    expect_out("R8 ctrl", 4, 32'h3);
    expect_out("R5 priv thread", 1, 0);
    // R7 unprivileged write dropped
    do_ctrl(32'h0, 0);
    expect_out("R7 ctrl", 4, 32'h3);
    expect_out("R7 psp_active", 2, 1);

    // R3 entry
    do_exc(1, 0, 0);
    expect_out("R3 mode entry", 0, 1);
    expect_out("R5 priv handler", 1, 1);
    expect_out("R6 msp in handler", 3, 32'h2000_0FF4);
    expect_out("R6 ctrl bit1 reads 0", 4, 32'h1);
    expect_out("R6 psp_active", 2, 0);
    // R6 handler write: bit0 taken, bit1 kept
    do_ctrl(32'h0, 1);
    expect_out("R6 ctrl after write", 4, 32'h0);
    do_sp(32'h2000_0F02);
    expect_out("R9 handler msp", 3, 32'h2000_0F00);
    // R3 nesting
    do_exc(1, 0, 0);
    expect_out("R3 nested", 0, 1);
    do_exc(0, 1, 0);
    expect_out("R3 return to handler", 0, 1);
    do_exc(0, 1, 1);
    expect_out("R3 return to thread", 0, 0);
    expect_out("R4 psp restored", 2, 1);
    expect_out("R9 psp kept", 3, 32'h1000_0ABC);
    expect_out("R6 bit1 kept", 4, 32'h2);
    expect_out("R5 priv restored", 1, 1);
    // R4 back to main stack
    do_ctrl(32'h0, 1);
    expect_out("R4 msp again", 3, 32'h2000_0F00);
    expect_out("R4 psp_active off", 2, 0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule